// File: doc/BRIEF.md
# Modulo Timer with Status and Control Register

This block is a 16-bit up-counter that wraps at a programmable modulo value, fed by a selectable count source. The source is either the bus clock divided by a power of two, or rising edges on an external timer pin. The counter's control and status sit in one 8-bit register on a simple bus with address, read strobe, write strobe, write data and registered read data. The same bus carries the modulo value and a read-only view of the counter, one byte at a time.

When the counter reaches the modulo value, it returns to zero on the next count tick and raises a sticky overflow flag. The flag drives an interrupt output through an enable bit. Software can clear the flag only with a read-then-write handshake, so an overflow that arrives during the clearing write is never lost. A stop bit freezes counting and is set out of reset. A write-only restart bit zeroes the counter and the prescaler in a single write.

Top module: `modtmr_top`

## Requirements
- R1: After reset the control register reads 0x20 (only stop set), the modulo reads 0xFFFF, the counter reads 0x0000 and `irq` is 0.
- R2: Address map (3-bit address): 0 = control, 1 = counter high byte, 2 = counter low byte, 3 = modulo high byte, 4 = modulo low byte. Read data appears on `bus_rdata` the cycle after `bus_rd`. Control bit layout: bit 7 overflow flag, bit 6 interrupt enable, bit 5 stop, bit 4 restart (write-only), bit 3 reserved and read as 0, bits 2:0 clock select.
- R3: On a count tick where the counter equals the modulo value, the counter loads 0x0000 and the overflow flag sets, both on that same clock edge.
- R4: Writing 1 to the overflow flag bit leaves the flag unchanged.
- R5: The flag clears only on a control write with bit 7 = 0 that follows a control read made while the flag was 1, with no other control write in between. A write of 0 without such a read leaves the flag set.
- R6: If an overflow falls on the same clock edge as a valid clearing write, the flag stays set.
- R7: `irq` is 1 exactly while both the overflow flag and the interrupt enable are 1. It changes on the same edge as either bit.
- R8: While stop is 1, the counter holds its value, including against external pin edges. Counting continues from that value once stop returns to 0.
- R9: A control write with bit 4 = 1 zeroes the counter and the prescaler on that edge. The same write still updates enable, stop and select as written, bit 4 always reads 0, and the modulo value is unaffected.
- R10: A single control write with both stop and restart set leaves the counter held at 0x0000.
- R11: Select codes 0 to 6 count once every 2^code bus clocks. After a restart the first tick falls on the 2^code-th following edge.
- R12: Select code 7 counts one tick per rising edge of `tmr_pin`, taken through a two-flop synchronizer.
- R13: The modulo is written as two separate byte writes and reads back as written. Writes to the counter addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_pin | input | 1 | External count input, asynchronous |
| irq | output | 1 | Overflow interrupt request |

## Verification
A hardware overflow and the software clearing write to the flag can fall on the same clock edge. The bench provokes this deterministically. It restarts the counter against a small modulo running at full bus rate, which fixes the cycle of every wrap. It then arms the clear with a control read and lands the 0-write exactly on a wrap edge. A shifted copy of the same sequence, whose write lands between wraps, must clear the flag. The collision case must leave the flag set and the counter one tick past zero.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_MOD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_MOD_LO = 3'd4;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_RST  = 4;
endpackage

// File: rtl/modtmr_prescale.sv
module modtmr_prescale
  import modtmr_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop,
  input  logic          restart,
  input  logic [SW-1:0] sel,
  input  logic          pin,
  output logic          tick
);
  localparam int NSRC  = 1 << SW;
  localparam int DIV_W = NSRC - 2;

  logic [DIV_W-1:0] pre_cnt;
  logic [2:0]       pin_sync;
  logic             pin_edge;
  logic [NSRC-1:0]  taps;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_cnt <= '0;
    else if (!stop)     pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_sync <= '0;
    else     pin_sync <= {pin_sync[1:0], pin};
  end

  assign pin_edge = pin_sync[1] & ~pin_sync[2];

  assign taps[0] = 1'b1;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign taps[k] = &pre_cnt[k-1:0];
  end
  assign taps[NSRC-1] = pin_edge;

  assign tick = !stop && !restart && taps[sel];

  AST_PRESCALE_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pre_cnt == '0)); // R9
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic at_mod;

  assign at_mod = (cnt == mod_val);
  assign hit    = tick && !restart && at_mod;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= at_mod ? '0 : cnt + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt)); // R8
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R9
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
  import modtmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int SW    = SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hit,
  output logic [DW-1:0]    rdata,
  output logic             stop,
  output logic             restart,
  output logic [SW-1:0]    sel,
  output logic [CNT_W-1:0] mod_val,
  output logic             irq
);
  localparam int HI_W = CNT_W - DW;

  logic wr_ctrl, rd_ctrl;
  logic flag_q, flag_d, ie_q, ie_d, armed;
  logic [DW-1:0] ctrl_view;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign rd_ctrl = rd && (addr == A_CTRL);
  assign restart = wr_ctrl && wdata[B_RST];
  assign ie_d    = wr_ctrl ? wdata[B_IE] : ie_q;

  always_comb begin
    flag_d = flag_q;
    if (hit)                                  flag_d = 1'b1;
    else if (wr_ctrl && armed && !wdata[B_FLAG]) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      stop   <= 1'b1;
      sel    <= '0;
      armed  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq    <= flag_d & ie_d;
      if (wr_ctrl) begin
        stop <= wdata[B_STOP];
        sel  <= wdata[SW-1:0];
      end
      if (wr_ctrl)                armed <= 1'b0;
      else if (rd_ctrl && flag_q) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mod_val <= '1;
    else if (wr && addr == A_MOD_HI) mod_val[CNT_W-1:DW] <= wdata[HI_W-1:0];
    else if (wr && addr == A_MOD_LO) mod_val[DW-1:0]     <= wdata;
  end

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_FLAG] = flag_q;
    ctrl_view[B_IE]   = ie_q;
    ctrl_view[B_STOP] = stop;
    ctrl_view[SW-1:0] = sel;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      case (addr)
        A_CTRL:   rdata <= ctrl_view;
        A_CNT_HI: rdata <= cnt[CNT_W-1:DW];
        A_CNT_LO: rdata <= cnt[DW-1:0];
        A_MOD_HI: rdata <= mod_val[CNT_W-1:DW];
        A_MOD_LO: rdata <= mod_val[DW-1:0];
        default:  rdata <= '0;
      endcase
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !armed) |=> flag_q); // R5
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q && ie_q)); // R7
  AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_ctrl) |-> !rdata[B_RST]); // R2
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_pin,
  output logic              irq
);
  logic             stop, restart, tick, hit;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] mod_val, cnt;

  modtmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .cnt(cnt), .hit(hit), .rdata(bus_rdata),
    .stop(stop), .restart(restart), .sel(sel), .mod_val(mod_val), .irq(irq)
  );

  modtmr_prescale u_pre (
    .clk(clk), .rst(rst), .stop(stop), .restart(restart), .sel(sel),
    .pin(tmr_pin), .tick(tick)
  );

  modtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .mod_val(mod_val), .cnt(cnt), .hit(hit)
  );
endmodule

// File: tb/modtmr_top_bench.sv
module modtmr_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tmr_pin = 1'b0;
  logic       irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  modtmr_top u_modtmr_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_pin(tmr_pin), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1; bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] h, l;
    rd(3'd1, h); rd(3'd2, l); v = {h, l};
  endtask

  task automatic set_mod(input int m);
    wr(3'd3, m[15:8]); wr(3'd4, m[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] d; int v;
    rd(3'd0, d); check("R1 ctrl", d, 8'h20);
    rd(3'd3, d); check("R1 mod hi", d, 8'hFF);
    rd(3'd4, d); check("R1 mod lo", d, 8'hFF);
    rd_cnt(v);   check("R1 count", v, 0);
    check("R1 irq", irq, 0);
    wr(3'd0, 8'h2F); rd(3'd0, d); check("R2 reserved bit", d, 8'h27);
    wr(3'd0, 8'h20);
  endtask

  task automatic t_map;
    logic [7:0] d; int v;
    set_mod(16'h1234);
    rd(3'd3, d); check("R13 mod hi", d, 8'h12);
    rd(3'd4, d); check("R13 mod lo", d, 8'h34);
    wr(3'd1, 8'h55); wr(3'd2, 8'hAA);
    rd_cnt(v); check("R13 count write ignored", v, 0);
    set_mod(16'hFFFF);
  endtask

  task automatic t_divide;
    int v;
    for (int code = 0; code < 7; code++) begin
      wr(3'd0, 8'h10 | code[7:0]);
      repeat (130) @(posedge clk);
      wr(3'd0, 8'h20 | code[7:0]);
      rd_cnt(v); check($sformatf("R11 divide code %0d", code), v, 131 >> code);
    end
  endtask

  task automatic t_stop;
    int v0, v;
    wr(3'd0, 8'h10); repeat (19) @(posedge clk); wr(3'd0, 8'h20);
    rd_cnt(v0); check("R8 run before stop", v0, 20);
    repeat (25) @(posedge clk);
    rd_cnt(v); check("R8 held while stopped", v, v0);
    wr(3'd0, 8'h00); repeat (9) @(posedge clk); wr(3'd0, 8'h20);
    rd_cnt(v); check("R8 resume from held value", v, v0 + 10);
  endtask

  task automatic t_restart;
    logic [7:0] d; int v;
    set_mod(16'h0345);
    wr(3'd0, 8'h52);
    rd(3'd0, d); check("R9 restart reads 0, fields kept", d, 8'h42);
    rd(3'd3, d); check("R9 mod hi untouched", d, 8'h03);
    rd(3'd4, d); check("R9 mod lo untouched", d, 8'h45);
    wr(3'd0, 8'h20);
    set_mod(16'hFFFF);
    wr(3'd0, 8'h00); repeat (10) @(posedge clk);
    wr(3'd0, 8'h30);
    rd_cnt(v); check("R10 stop+restart zero", v, 0);
    repeat (20) @(posedge clk);
    rd_cnt(v); check("R10 held at zero", v, 0);
  endtask

  task automatic t_wrap_clear;
    logic [7:0] d; int v;
    set_mod(4);
    wr(3'd0, 8'h10); repeat (2) @(posedge clk); wr(3'd0, 8'h20);
    rd_cnt(v); check("R3 below modulo", v, 3);
    wr(3'd0, 8'h10); repeat (6) @(posedge clk); wr(3'd0, 8'h20);
    rd_cnt(v); check("R3 wrapped count", v, 2);
    wr(3'd0, 8'h20);
    rd(3'd0, d); check("R5 zero-write without read keeps flag", d, 8'hA0);
    wr(3'd0, 8'h20);
    rd(3'd0, d); check("R5 read then zero-write clears", d, 8'h20);
    wr(3'd0, 8'hA0);
    rd(3'd0, d); check("R4 writing 1 to flag", d, 8'h20);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(3'd0, 8'h10); repeat (6) @(posedge clk); wr(3'd0, 8'h20);
    check("R7 irq off while disabled", irq, 0);
    wr(3'd0, 8'h60); check("R7 irq on with enable", irq, 1);
    wr(3'd0, 8'h20); check("R7 irq off when enable cleared", irq, 0);
    rd(3'd0, d); wr(3'd0, 8'h20);
    rd(3'd0, d); check("R5 cleanup clear", d, 8'h20);
  endtask

  task automatic t_collide;
    logic [7:0] d; int v;
    set_mod(3);
    wr(3'd0, 8'h10); repeat (4) @(posedge clk);
    rd(3'd0, d); check("R3 flag set at wrap", d, 8'h80);
    wr(3'd0, 8'h00); wr(3'd0, 8'hA0);
    rd(3'd0, d); check("R6 clear off wrap edge", d, 8'h20);
    wr(3'd0, 8'h10); repeat (4) @(posedge clk);
    rd(3'd0, d);
    repeat (2) @(posedge clk);
    wr(3'd0, 8'h00); wr(3'd0, 8'hA0);
    rd(3'd0, d); check("R6 set wins over clear", d, 8'hA0);
    rd_cnt(v); check("R6 count after collision", v, 1);
    rd(3'd0, d); wr(3'd0, 8'h20);
    set_mod(16'hFFFF);
  endtask

  task automatic t_ext;
    int v;
    wr(3'd0, 8'h17);
    for (int i = 0; i < 5; i++) begin
      tmr_pin = 1'b1; repeat (4) @(posedge clk); #1;
      tmr_pin = 1'b0; repeat (4) @(posedge clk); #1;
    end
    repeat (5) @(posedge clk);
    wr(3'd0, 8'h27);
    rd_cnt(v); check("R12 external edges", v, 5);
    for (int i = 0; i < 3; i++) begin
      tmr_pin = 1'b1; repeat (4) @(posedge clk); #1;
      tmr_pin = 1'b0; repeat (4) @(posedge clk); #1;
    end
    rd_cnt(v); check("R8 external edges while stopped", v, 5);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    t_reset();
    t_map();
    t_divide();
    t_stop();
    t_restart();
    t_wrap_clear();
    t_irq();
    t_collide();
    t_ext();
    finish_run();
  end
endmodule